// File: doc/BRIEF.md
# SPI Test Pattern Transmitter

This block is a transmit-only SPI master that sends a fixed, repeating test pattern to an attached slave. It drives three outputs: a serial clock, a serial data line and an active-low chip select. The block makes the serial clock from the system clock with a programmable half-period divider. It frames each byte in its own chip-select window and shifts the byte out most significant bit first. It then raises chip select and holds it high for a programmable idle gap before the next byte.

While `enable` is high, the block cycles through the bytes 0x55, 0xF0, 0xC0 and 0xC3 and then starts again. Dropping `enable` does not cut a byte short: the byte and its gap finish first. The position in the pattern is kept, so the next run resumes with the following byte. Only reset returns the pattern to its first byte. `busy` reports when a frame or its gap is in progress.

Top module: `spi_pat_tx`

## Requirements
- R1: During and after reset, `spi_cs_n` is 1, `spi_sclk` is 0 and `busy` is 0. The first frame after reset, including a reset in the middle of a frame, carries 0x55.
- R2: With `enable` held high, the frames carry 0x55, 0xF0, 0xC0, 0xC3 and then repeat from 0x55.
- R3: Each byte is shifted out most significant bit first. The bit present on `spi_sdo` at the k-th rising edge of `spi_sclk` in a frame is bit 7-(k-1).
- R4: Each frame, meaning a stretch with `spi_cs_n` low, contains exactly 8 rising edges of `spi_sclk`. `spi_sclk` idles low and is high only while `spi_cs_n` is low.
- R5: `spi_cs_n` falls HALF_DIV system clocks before the first rising edge of `spi_sclk`. It rises HALF_DIV system clocks after the last falling edge, so it never rises while `spi_sclk` is high.
- R6: `spi_sdo` changes only while `spi_sclk` is low. It does not change in the cycle `spi_sclk` rises, nor while it stays high.
- R7: Every high phase of `spi_sclk` lasts HALF_DIV system clocks, and so does every low phase between two pulses of a frame.
- R8: With `enable` held high, `spi_cs_n` stays high for exactly GAP_CYC system clocks between consecutive frames.
- R9: `busy` is 1 for every cycle with `spi_cs_n` low and for the GAP_CYC cycles of the gap that follows. While `enable` is low and the block is idle, no frame starts: `spi_cs_n` stays 1, `spi_sclk` stays 0 and `busy` stays 0.
- R10: If `enable` falls during a frame, the frame completes with all 8 bits and its gap. The block then goes idle, with `busy` at 0. When `enable` rises again, the next frame carries the pattern byte after the one last sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Allows new frames to start |
| busy | output | 1 | High from chip-select fall until the end of the following gap |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_sdo | output | 1 | Serial data, MSB first, valid at the rising serial clock edge |
| spi_cs_n | output | 1 | Chip select, active low, one window per byte |

## Verification
The bench builds the block with HALF_DIV = 2 and GAP_CYC = 5. A half-period of two system clocks makes the divider's count visible: a phase that is one cycle short or long shows up as a wrong measured length, and a stuck or unloaded count stalls the frame. With a gap of five cycles, six back-to-back frames, which is more than one full pass of the pattern and its wrap, fit in a few hundred cycles. There is then room left for the cases with `enable` dropped mid-frame, with `enable` held low, and with reset applied mid-frame.

// File: rtl/spi_pat_pkg.sv
// Shared constants, state type and pattern lookup for the SPI pattern transmitter.
// Assumes a fixed byte width of 8 and a four-entry pattern.
package spi_pat_pkg;

    localparam int BYTE_W  = 8;
    localparam int PAT_LEN = 4;
    localparam int IDX_W   = $clog2(PAT_LEN);

    // Framer states: idle, chip-select lead-in, clock high, clock low,
    // chip-select tail after the last pulse, idle gap between frames.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LEAD = 3'd1,
        ST_HIGH = 3'd2,
        ST_LOW  = 3'd3,
        ST_TAIL = 3'd4,
        ST_GAP  = 3'd5
    } frm_state_t;

    // Pattern byte for a given position in the sequence.
    function automatic logic [BYTE_W-1:0] pat_byte(input logic [IDX_W-1:0] idx);
        logic [BYTE_W-1:0] b;
        case (idx)
            2'd0:    b = 8'h55;
            2'd1:    b = 8'hF0;
            2'd2:    b = 8'hC0;
            default: b = 8'hC3;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/spi_pat_timer.sv
// Load-and-count-down phase timer.
// A load sets the count to load_val. Otherwise the count falls by one per
// cycle and stops at zero, and `expired` is high while the count is zero.
// A load of N-1 therefore keeps the caller's state for N cycles.
module spi_pat_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Count down toward zero, or take a new value when loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R7
    timer_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load) && $past(cnt) != '0) |-> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/spi_pat_seq.sv
// Pattern position holder.
// The position advances by one, wrapping after the last entry, each cycle
// `advance` is high. It returns to the first entry only on reset.
// Assumes `advance` is a one-cycle pulse per completed frame.
module spi_pat_seq
    import spi_pat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [BYTE_W-1:0] byte_out
);

    logic [IDX_W-1:0] idx;

    // Step the pattern position, wrapping at the end of the pattern.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (advance)
            idx <= (idx == IDX_W'(PAT_LEN - 1)) ? '0 : idx + 1'b1;
    end

    assign byte_out = pat_byte(idx);

    // R1
    seq_reset_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (byte_out == 8'h55));

    // R10
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(advance)) |-> $stable(idx));

endmodule

// File: rtl/spi_pat_framer.sv
// Frame sequencer and shift register for the SPI pattern transmitter.
// Each frame follows the same order: lower chip select and present the MSB,
// then give eight clock pulses. Data shifts on each falling edge. After the
// last pulse, one low half-period passes before chip select rises. A gap of
// GAP_CYC clocks follows, with chip select high.
// All outputs come straight from flops.
// Assumes HALF_DIV >= 1 and GAP_CYC >= 1, and an external phase timer
// whose `tmr_done` goes high N cycles after a load of N-1.
module spi_pat_framer
    import spi_pat_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int GAP_CYC  = 16,
    parameter int CNT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              tmr_done,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              advance,
    output logic              busy,
    output logic              sclk,
    output logic              cs_n,
    output logic              sdo
);

    localparam int BCNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  HALF_LD = CNT_W'(HALF_DIV - 1);
    localparam logic [CNT_W-1:0]  GAP_LD  = CNT_W'(GAP_CYC - 1);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W - 1);

    frm_state_t         state, nxt;
    logic [BYTE_W-1:0]  shreg;
    logic [BCNT_W-1:0]  bit_cnt;
    logic               load_byte, shift_bit, bit_inc;

    // Choose the next state and the timer and shift strobes for this cycle.
    always_comb begin
        nxt       = state;
        tmr_load  = 1'b0;
        tmr_val   = HALF_LD;
        load_byte = 1'b0;
        shift_bit = 1'b0;
        bit_inc   = 1'b0;
        advance   = 1'b0;
        case (state)
            ST_IDLE: begin
                if (enable) begin
                    nxt       = ST_LEAD;
                    tmr_load  = 1'b1;
                    load_byte = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tmr_done) begin
                    nxt      = ST_HIGH;
                    tmr_load = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    bit_inc  = 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        nxt = ST_TAIL;
                    end else begin
                        nxt       = ST_LOW;
                        shift_bit = 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    nxt      = ST_HIGH;
                    tmr_load = 1'b1;
                end
            end
            ST_TAIL: begin
                if (tmr_done) begin
                    nxt      = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = GAP_LD;
                    advance  = 1'b1;
                end
            end
            ST_GAP: begin
                if (tmr_done) begin
                    if (enable) begin
                        nxt       = ST_LEAD;
                        tmr_load  = 1'b1;
                        load_byte = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Shift register: load a fresh byte at frame start, shift left on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (load_byte)
            shreg <= byte_in;
        else if (shift_bit)
            shreg <= {shreg[BYTE_W-2:0], 1'b0};
    end

    // Count the clock pulses given in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_cnt <= '0;
        else if (load_byte)
            bit_cnt <= '0;
        else if (bit_inc)
            bit_cnt <= bit_cnt + 1'b1;
    end

    // Registered line outputs decoded from the next state, so the lines never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            sclk <= 1'b0;
            busy <= 1'b0;
        end else begin
            cs_n <= (nxt == ST_IDLE) || (nxt == ST_GAP);
            sclk <= (nxt == ST_HIGH);
            busy <= (nxt != ST_IDLE);
        end
    end

    assign sdo = shreg[BYTE_W-1];

    // R4
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R4
    pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= BCNT_W'(BYTE_W));

    // R6
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sclk) |-> $stable(sdo));

    // R5
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(cs_n)) |-> !$past(sclk));

    // R9
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    // R10
    stop_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(busy)) |-> ($past(state) == ST_GAP && cs_n));

endmodule

// File: rtl/spi_pat_tx.sv
// SPI test pattern transmitter, top level.
// Joins the phase timer, the pattern position holder and the framer.
// Parameters: HALF_DIV is the number of system clocks per serial clock half
// period, and GAP_CYC is the number of system clocks of idle gap between
// frames. Both must be at least 1.
module spi_pat_tx
    import spi_pat_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int GAP_CYC  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic busy,
    output logic spi_sclk,
    output logic spi_sdo,
    output logic spi_cs_n
);

    localparam int MAX_LD = (HALF_DIV > GAP_CYC) ? HALF_DIV : GAP_CYC;
    localparam int CNT_W  = (MAX_LD < 2) ? 1 : $clog2(MAX_LD);

    logic              tmr_load, tmr_done, advance;
    logic [CNT_W-1:0]  tmr_val;
    logic [BYTE_W-1:0] cur_byte;

    spi_pat_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    spi_pat_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .byte_out (cur_byte)
    );

    spi_pat_framer #(
        .HALF_DIV (HALF_DIV),
        .GAP_CYC  (GAP_CYC),
        .CNT_W    (CNT_W)
    ) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .byte_in  (cur_byte),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .advance  (advance),
        .busy     (busy),
        .sclk     (spi_sclk),
        .cs_n     (spi_cs_n),
        .sdo      (spi_sdo)
    );

endmodule

// File: tb/spi_pat_tx_test.sv
// Bench for spi_pat_tx. It samples on the falling system clock edge and
// rebuilds each frame from the serial lines.
module spi_pat_tx_test;

    localparam int HALF = 2;
    localparam int GAP  = 5;
    localparam int GAP_LIMIT = 200;
    localparam int NVEC = 6;
    localparam logic [7:0] EXP_SEQ [0:NVEC-1] = '{8'h55, 8'hF0, 8'hC0, 8'hC3, 8'h55, 8'hF0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic busy, spi_sclk, spi_sdo, spi_cs_n;

    int n_checks = 0;
    int n_err = 0;

    logic [7:0] f_byte;
    int f_pulses, f_lead, f_tail, f_gap;
    bit f_hi_bad, f_lo_bad, f_sdo_bad, f_busy_bad;

    always #5 clk = ~clk;

    spi_pat_tx #(.HALF_DIV(HALF), .GAP_CYC(GAP)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .busy     (busy),
        .spi_sclk (spi_sclk),
        .spi_sdo  (spi_sdo),
        .spi_cs_n (spi_cs_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Rebuild one frame from the lines, then measure the gap that follows.
    task automatic grab_frame();
        bit ps;
        logic pd;
        int hi_run, lo_run;
        f_byte = '0; f_pulses = 0; f_lead = -1; f_tail = -1; f_gap = 0;
        f_hi_bad = 0; f_lo_bad = 0; f_sdo_bad = 0; f_busy_bad = 0;
        while (spi_cs_n !== 1'b0) @(negedge clk);
        ps = 1'b0; pd = spi_sdo; hi_run = 0; lo_run = 0;
        while (spi_cs_n === 1'b0) begin
            if (busy !== 1'b1) f_busy_bad = 1;
            if (spi_sclk === 1'b1) begin
                if (spi_sdo !== pd) f_sdo_bad = 1;
                if (!ps) begin
                    if (f_pulses == 0) f_lead = lo_run;
                    else if (lo_run != HALF) f_lo_bad = 1;
                    f_pulses++;
                    f_byte = {f_byte[6:0], spi_sdo};
                    lo_run = 0;
                end
                hi_run++;
            end else begin
                if (ps) begin
                    if (hi_run != HALF) f_hi_bad = 1;
                    hi_run = 0;
                end
                lo_run++;
            end
            ps = spi_sclk; pd = spi_sdo;
            @(negedge clk);
        end
        f_tail = ps ? 0 : lo_run;
        while (spi_cs_n === 1'b1 && f_gap < GAP_LIMIT) begin
            if (f_gap < GAP && busy !== 1'b1) f_busy_bad = 1;
            if (spi_sclk !== 1'b0) f_hi_bad = 1;
            f_gap++;
            @(negedge clk);
        end
    endtask

    task automatic check_frame(input logic [7:0] exp, input bit cont);
        check(f_byte == exp, "R2/R3", "frame byte", f_byte, exp);
        check(f_pulses == 8, "R4", "pulses per frame", f_pulses, 8);
        check(f_lead == HALF, "R5", "cs lead before first rise", f_lead, HALF);
        check(f_tail == HALF, "R5", "cs tail after last fall", f_tail, HALF);
        check(!f_sdo_bad, "R6", "sdo change while sclk high", f_sdo_bad, 0);
        check(!f_hi_bad && !f_lo_bad, "R7", "half-period length", {f_hi_bad, f_lo_bad}, 0);
        check(!f_busy_bad, "R9", "busy through frame and gap", f_busy_bad, 0);
        if (cont) check(f_gap == GAP, "R8", "idle gap length", f_gap, GAP);
    endtask

    // Watchdog: a hung run is one failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog (R1..R10 run): actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        bit idle_bad;
        // R1: outputs held idle during reset
        repeat (4) @(negedge clk);
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && busy === 1'b0, "R1",
              "reset state {cs_n,sclk,busy}", {spi_cs_n, spi_sclk, busy}, 3'b100);
        rst_n = 1'b1;

        // R9: enable low means no frame starts
        idle_bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (spi_cs_n !== 1'b1 || spi_sclk !== 1'b0 || busy !== 1'b0) idle_bad = 1;
        end
        check(!idle_bad, "R9", "idle while enable low", idle_bad, 0);

        // Table walk: back-to-back frames, with the pattern wrap (R2, R8)
        enable = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            grab_frame();
            check_frame(EXP_SEQ[i], 1'b1);
        end

        // R10: drop enable mid-frame; the 0xC0 frame still completes
        fork
            grab_frame();
            begin
                repeat (10) @(negedge clk);
                enable = 1'b0;
            end
        join
        check_frame(8'hC0, 1'b0);
        check(f_gap == GAP_LIMIT, "R10", "no frame after disable", f_gap, GAP_LIMIT);
        idle_bad = 0;
        repeat (30) begin
            @(negedge clk);
            if (spi_cs_n !== 1'b1 || busy !== 1'b0) idle_bad = 1;
        end
        check(!idle_bad, "R10", "idle and not busy after stop", idle_bad, 0);

        // R10: resume continues the pattern with 0xC3
        enable = 1'b1;
        grab_frame();
        check_frame(8'hC3, 1'b1);
        grab_frame();
        check_frame(8'h55, 1'b1);

        // R1: reset in the middle of the 0xF0 frame restarts at 0x55
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && busy === 1'b0, "R1",
              "mid-frame reset state {cs_n,sclk,busy}", {spi_cs_n, spi_sclk, busy}, 3'b100);
        rst_n = 1'b1;
        grab_frame();
        check(f_byte == 8'h55, "R1", "first byte after reset", f_byte, 8'h55);
        check_frame(8'h55, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule